// File: doc/BRIEF.md
# Address Cacheability Decision Unit

This block decides whether a 32-bit virtual address may be cached. Each request carries an address and a mode context: a privileged flag, a translation-bypass flag, a single-virtual-mode flag and the current address-space ID (ASID). The decision comes back one clock later as a single cacheable bit.

The block makes the decision in three steps. First, a region screen forces an uncached result for address windows that the current mode never caches. Second, when translation is bypassed, any address that passes the screen is cacheable. Otherwise the block searches two fully associative translation tables in a fixed order: a small instruction table first, then a larger unified table. The first hit supplies the entry's cacheable attribute, and a miss in both tables gives an uncached result.

Each table has its own write port, which loads one entry per cycle. Reset invalidates every entry in both tables.

Top module: `cache_attr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` and `rsp_cacheable` are 0. Reset invalidates every entry of both tables, so a translated lookup after reset with no writes returns 0.
- R2: With `req_priv`=1, an address in the range 0xA0000000 to 0xBFFFFFFF gives `rsp_cacheable`=0. This holds regardless of bypass or any table hit.
- R3: With `req_priv`=1, an address at or above 0xE0000000 gives `rsp_cacheable`=0.
- R4: With `req_priv`=0, an address at or above 0x80000000 gives `rsp_cacheable`=0. This holds regardless of bypass or any table hit.
- R5: With `req_bypass`=1, an address that passes the region screen gives `rsp_cacheable`=1, whatever the tables hold.
- R6: An entry hits when all of the following are true:
  - its valid bit is set;
  - its 22-bit page number equals address bits [31:10];
  - the ASID check passes (see R7).
- R7: The ASID check is skipped only when `req_priv`=1 and `req_sv`=1. Otherwise the check passes when the entry's shared bit is 1 or when the entry's ASID equals `req_asid`.
- R8: The instruction table is searched first. On a hit there, the result is that entry's cacheable bit, even if the unified table also hits.
- R9: On an instruction-table miss, a unified-table hit gives that entry's cacheable bit.
- R10: When translation is not bypassed and neither table hits, the result is 0.
- R11: `rsp_valid` is 1 in the cycle after a cycle with `req_valid`=1, and 0 after a cycle without it. `rsp_cacheable` is 0 whenever `rsp_valid` is 0.
- R12: A lookup issued in the same cycle as a write to a matching entry sees the table contents from before that write. The next lookup sees the new contents.
- R13: When several entries of one table hit, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Virtual address to classify |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_bypass | input | 1 | 1 = translation bypassed, no table search |
| req_sv | input | 1 | Single-virtual-mode flag |
| req_asid | input | 8 | Current address-space ID |
| it_wr_en | input | 1 | Instruction-table write strobe |
| it_wr_idx | input | 2 | Instruction-table entry index |
| it_wr_valid | input | 1 | Valid bit to write |
| it_wr_vpn | input | 22 | Page number to write |
| it_wr_asid | input | 8 | ASID to write |
| it_wr_shared | input | 1 | Shared bit to write |
| it_wr_cache | input | 1 | Cacheable bit to write |
| ut_wr_en | input | 1 | Unified-table write strobe |
| ut_wr_idx | input | 6 | Unified-table entry index |
| ut_wr_valid | input | 1 | Valid bit to write |
| ut_wr_vpn | input | 22 | Page number to write |
| ut_wr_asid | input | 8 | ASID to write |
| ut_wr_shared | input | 1 | Shared bit to write |
| ut_wr_cache | input | 1 | Cacheable bit to write |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_cacheable | output | 1 | 1 = address may be cached |

## Verification
An entry write and a lookup that depends on that same entry can fall in the same cycle. The bench provokes this in two ways:
- it invalidates an instruction entry while looking up its page;
- it fills an empty unified entry while looking up the page that entry covers.

A scoreboard expects the pre-write answer for the colliding lookup and the post-write answer for the lookup one cycle later. A separate case overlaps the region screen with a valid table hit, to show that the screen always wins.

// File: rtl/cattr_pkg.sv
package cattr_pkg;
  localparam int ADDR_W = 32;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int PG_LSB = ADDR_W - VPN_W;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic              cache;
  } xlat_entry_t;

  // One entry against a lookup key; ASID is honoured only when use_asid is set.
  function automatic logic entry_hit(xlat_entry_t e, logic [VPN_W-1:0] vpn,
                                     logic [ASID_W-1:0] asid, logic use_asid);
    return e.valid && (e.vpn == vpn) &&
           (!use_asid || e.shared || (e.asid == asid));
  endfunction

  // Mode-dependent windows that are never cacheable.
  function automatic logic region_blocked(logic [ADDR_W-1:0] a, logic priv);
    if (priv)
      return (a[ADDR_W-1 -: 3] == 3'b101) || (a[ADDR_W-1 -: 3] == 3'b111);
    else
      return a[ADDR_W-1];
  endfunction

  function automatic logic asid_in_use(logic priv, logic sv);
    return !(priv && sv);
  endfunction
endpackage

// File: rtl/cattr_region.sv
module cattr_region
  import cattr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  output logic              blocked
);
  always_comb blocked = region_blocked(addr, priv);
endmodule

// File: rtl/cattr_table.sv
module cattr_table
  import cattr_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  xlat_entry_t       wr_entry,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_use_asid,
  output logic              hit,
  output logic              cacheable
);
  xlat_entry_t ent [DEPTH];
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i].valid <= 1'b0;
    end else if (wr_en) begin
      ent[wr_idx] <= wr_entry;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = entry_hit(ent[g], lk_vpn, lk_asid, lk_use_asid);
  end

  // Lowest index wins: scan downwards so the last assignment is the lowest.
  always_comb begin
    hit       = 1'b0;
    cacheable = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit       = 1'b1;
        cacheable = ent[i].cache;
      end
    end
  end
endmodule

// File: rtl/cache_attr_unit.sv
module cache_attr_unit
  import cattr_pkg::*;
#(
  parameter int IT_DEPTH = 4,
  parameter int UT_DEPTH = 64,
  localparam int IT_IW = $clog2(IT_DEPTH),
  localparam int UT_IW = $clog2(UT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_priv,
  input  logic              req_bypass,
  input  logic              req_sv,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              it_wr_en,
  input  logic [IT_IW-1:0]  it_wr_idx,
  input  logic              it_wr_valid,
  input  logic [VPN_W-1:0]  it_wr_vpn,
  input  logic [ASID_W-1:0] it_wr_asid,
  input  logic              it_wr_shared,
  input  logic              it_wr_cache,
  input  logic              ut_wr_en,
  input  logic [UT_IW-1:0]  ut_wr_idx,
  input  logic              ut_wr_valid,
  input  logic [VPN_W-1:0]  ut_wr_vpn,
  input  logic [ASID_W-1:0] ut_wr_asid,
  input  logic              ut_wr_shared,
  input  logic              ut_wr_cache,
  output logic              rsp_valid,
  output logic              rsp_cacheable
);
  xlat_entry_t it_entry, ut_entry;
  logic [VPN_W-1:0] lk_vpn;
  logic use_asid;
  logic screen_block;
  logic it_hit, it_cacheable;
  logic ut_hit, ut_cacheable;
  logic decision;

  assign it_entry = '{valid: it_wr_valid, vpn: it_wr_vpn, asid: it_wr_asid,
                      shared: it_wr_shared, cache: it_wr_cache};
  assign ut_entry = '{valid: ut_wr_valid, vpn: ut_wr_vpn, asid: ut_wr_asid,
                      shared: ut_wr_shared, cache: ut_wr_cache};
  assign lk_vpn   = req_addr[ADDR_W-1:PG_LSB];
  assign use_asid = asid_in_use(req_priv, req_sv);

  cattr_region u_region (
    .addr    (req_addr),
    .priv    (req_priv),
    .blocked (screen_block)
  );

  cattr_table #(.DEPTH(IT_DEPTH)) u_itab (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (it_wr_en),
    .wr_idx      (it_wr_idx),
    .wr_entry    (it_entry),
    .lk_vpn      (lk_vpn),
    .lk_asid     (req_asid),
    .lk_use_asid (use_asid),
    .hit         (it_hit),
    .cacheable   (it_cacheable)
  );

  cattr_table #(.DEPTH(UT_DEPTH)) u_utab (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (ut_wr_en),
    .wr_idx      (ut_wr_idx),
    .wr_entry    (ut_entry),
    .lk_vpn      (lk_vpn),
    .lk_asid     (req_asid),
    .lk_use_asid (use_asid),
    .hit         (ut_hit),
    .cacheable   (ut_cacheable)
  );

  always_comb begin
    if (screen_block)    decision = 1'b0;
    else if (req_bypass) decision = 1'b1;
    else if (it_hit)     decision = it_cacheable;
    else if (ut_hit)     decision = ut_cacheable;
    else                 decision = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_cacheable <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_cacheable <= req_valid & decision;
    end
  end
endmodule

// File: rtl/cattr_checker.sv
module cattr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_priv,
  input logic        req_bypass,
  input logic        rsp_valid,
  input logic        rsp_cacheable,
  input logic        screen_block,
  input logic        it_hit,
  input logic        it_cacheable,
  input logic        ut_hit
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_cacheable)); // R11
  AST_PRIV_MID_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && req_addr >= 32'hA000_0000 && req_addr < 32'hC000_0000)
      |=> !rsp_cacheable); // R2
  AST_PRIV_TOP_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && req_addr >= 32'hE000_0000) |=> !rsp_cacheable); // R3
  AST_USER_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && req_addr >= 32'h8000_0000) |=> !rsp_cacheable); // R4
  AST_BYPASS_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bypass && !screen_block) |=> rsp_cacheable); // R5
  AST_ITAB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_bypass && !screen_block && it_hit)
      |=> (rsp_cacheable == $past(it_cacheable))); // R8
  AST_DOUBLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_bypass && !it_hit && !ut_hit) |=> !rsp_cacheable); // R10
endmodule

bind cache_attr_unit cattr_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_priv      (req_priv),
  .req_bypass    (req_bypass),
  .rsp_valid     (rsp_valid),
  .rsp_cacheable (rsp_cacheable),
  .screen_block  (screen_block),
  .it_hit        (it_hit),
  .it_cacheable  (it_cacheable),
  .ut_hit        (ut_hit)
);

// File: tb/cache_attr_unit_tb.sv
`timescale 1ns/1ps
module cache_attr_unit_tb;
  typedef struct {
    logic  exp;
    string tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_priv = 0, req_bypass = 0, req_sv = 0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_asid = '0;
  logic it_wr_en = 0, it_wr_valid = 0, it_wr_shared = 0, it_wr_cache = 0;
  logic [1:0]  it_wr_idx = '0;
  logic [21:0] it_wr_vpn = '0;
  logic [7:0]  it_wr_asid = '0;
  logic ut_wr_en = 0, ut_wr_valid = 0, ut_wr_shared = 0, ut_wr_cache = 0;
  logic [5:0]  ut_wr_idx = '0;
  logic [21:0] ut_wr_vpn = '0;
  logic [7:0]  ut_wr_asid = '0;
  logic rsp_valid, rsp_cacheable;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;

  cache_attr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .req_bypass(req_bypass), .req_sv(req_sv), .req_asid(req_asid),
    .it_wr_en(it_wr_en), .it_wr_idx(it_wr_idx), .it_wr_valid(it_wr_valid),
    .it_wr_vpn(it_wr_vpn), .it_wr_asid(it_wr_asid), .it_wr_shared(it_wr_shared),
    .it_wr_cache(it_wr_cache),
    .ut_wr_en(ut_wr_en), .ut_wr_idx(ut_wr_idx), .ut_wr_valid(ut_wr_valid),
    .ut_wr_vpn(ut_wr_vpn), .ut_wr_asid(ut_wr_asid), .ut_wr_shared(ut_wr_shared),
    .ut_wr_cache(ut_wr_cache),
    .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R11 unexpected response", 1'b1, 1'b0);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        check(it.tag, rsp_cacheable, it.exp);
      end
    end
  end

  task automatic set_req(input logic [31:0] a, input logic priv, input logic byp,
                         input logic sv, input logic [7:0] asid,
                         input logic exp, input string tag);
    sb_item_t it;
    req_valid = 1; req_addr = a; req_priv = priv; req_bypass = byp;
    req_sv = sv; req_asid = asid;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_wr(input bit uni, input int idx, input logic v,
                        input logic [21:0] vpn, input logic [7:0] asid,
                        input logic sh, input logic c);
    if (uni) begin
      ut_wr_en = 1; ut_wr_idx = 6'(idx); ut_wr_valid = v; ut_wr_vpn = vpn;
      ut_wr_asid = asid; ut_wr_shared = sh; ut_wr_cache = c;
    end else begin
      it_wr_en = 1; it_wr_idx = 2'(idx); it_wr_valid = v; it_wr_vpn = vpn;
      it_wr_asid = asid; it_wr_shared = sh; it_wr_cache = c;
    end
  endtask

  task automatic step();
    @(negedge clk);
    req_valid = 0; it_wr_en = 0; ut_wr_en = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic priv, input logic byp,
                        input logic sv, input logic [7:0] asid,
                        input logic exp, input string tag);
    set_req(a, priv, byp, sv, asid, exp, tag);
    step();
  endtask

  task automatic wr(input bit uni, input int idx, input logic v, input logic [21:0] vpn,
                    input logic [7:0] asid, input logic sh, input logic c);
    set_wr(uni, idx, v, vpn, asid, sh, c);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid after reset", rsp_valid, 1'b0);
    check("R1 rsp_cacheable after reset", rsp_cacheable, 1'b0);

    lookup(32'h0000_1000, 0, 0, 0, 8'd3, 1'b0, "R1 R10 empty tables miss");
    // Bypass and region screen
    lookup(32'h0000_1000, 0, 1, 0, 8'd0, 1'b1, "R5 user low bypass");
    lookup(32'h8000_0000, 0, 1, 0, 8'd0, 1'b0, "R4 user upper bypass");
    lookup(32'h8000_0000, 1, 1, 0, 8'd0, 1'b1, "R5 priv 0x80000000 bypass");
    lookup(32'h9FFF_FFFF, 1, 1, 0, 8'd0, 1'b1, "R5 priv below hole");
    lookup(32'hA000_0000, 1, 1, 0, 8'd0, 1'b0, "R2 priv hole start");
    lookup(32'hBFFF_FFFC, 1, 1, 0, 8'd0, 1'b0, "R2 priv hole end");
    lookup(32'hC000_0000, 1, 1, 0, 8'd0, 1'b1, "R5 priv after hole");
    lookup(32'hDFFF_FFFF, 1, 1, 0, 8'd0, 1'b1, "R5 priv below top");
    lookup(32'hE000_0000, 1, 1, 0, 8'd0, 1'b0, "R3 priv top region");
    @(negedge clk);
    check("R11 idle cycle has no response", rsp_valid, 1'b0);

    // Unified table, page 0x4 (addr 0x1000), ASID 3
    wr(1, 5, 1, 22'h4, 8'd3, 0, 1);
    lookup(32'h0000_1000, 0, 0, 0, 8'd3, 1'b1, "R9 R6 unified hit");
    lookup(32'h0000_13FC, 0, 0, 0, 8'd3, 1'b1, "R6 same page offset");
    lookup(32'h0000_1400, 0, 0, 0, 8'd3, 1'b0, "R6 next page misses");
    lookup(32'h0000_1000, 0, 0, 0, 8'd4, 1'b0, "R7 user asid mismatch");
    lookup(32'h0000_1000, 1, 0, 1, 8'd4, 1'b1, "R7 priv+sv ignores asid");
    lookup(32'h0000_1000, 1, 0, 0, 8'd4, 1'b0, "R7 priv sv=0 compares asid");
    lookup(32'h0000_1000, 0, 0, 1, 8'd4, 1'b0, "R7 user sv=1 compares asid");

    // Instruction table takes precedence
    wr(0, 2, 1, 22'h4, 8'd3, 0, 0);
    lookup(32'h0000_1000, 0, 0, 0, 8'd3, 1'b0, "R8 itab first");

    // Shared entry and lowest-index priority
    wr(1, 9, 1, 22'h5, 8'd7, 1, 1);
    lookup(32'h0000_1400, 0, 0, 0, 8'd1, 1'b1, "R7 shared matches any asid");
    wr(1, 10, 1, 22'h5, 8'd7, 1, 0);
    lookup(32'h0000_1400, 0, 0, 0, 8'd1, 1'b1, "R13 lowest index wins");
    wr(1, 9, 0, 22'h5, 8'd7, 1, 1);
    lookup(32'h0000_1400, 0, 0, 0, 8'd1, 1'b0, "R13 next entry after invalidate");

    // Region screen overrides a table hit
    wr(1, 0, 1, 22'h20_0000, 8'd0, 1, 1);
    lookup(32'h8000_0000, 0, 0, 0, 8'd0, 1'b0, "R4 user upper with hit");
    wr(1, 1, 1, 22'h28_0000, 8'd0, 1, 1);
    lookup(32'hA000_0000, 1, 0, 0, 8'd0, 1'b0, "R2 priv hole with hit");

    // Same-cycle write and lookup
    set_wr(0, 2, 0, 22'h4, 8'd3, 0, 0);
    set_req(32'h0000_1000, 0, 0, 0, 8'd3, 1'b0, "R12 lookup sees old itab entry");
    step();
    lookup(32'h0000_1000, 0, 0, 0, 8'd3, 1'b1, "R12 next lookup sees invalidation");
    set_wr(1, 11, 1, 22'h6, 8'd3, 0, 1);
    set_req(32'h0000_1800, 0, 0, 0, 8'd3, 1'b0, "R12 fill not yet visible");
    step();
    lookup(32'h0000_1800, 0, 0, 0, 8'd3, 1'b1, "R12 fill visible next cycle");

    repeat (3) @(negedge clk);
    check("R11 all responses seen", (sb.size() == 0), 1'b1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule